// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits behind the receive byte parser of an Ethernet port and decides, for every incoming frame, whether the frame is kept. It collects the six destination address bytes as they stream in and checks the 48-bit result in three ways. The first is a bank of exact-match slots. The second is a 64-bit multicast hash table indexed by a 6-bit XOR fold of the address. The third is a pair of mode switches: promiscuous and all-multicast. One cycle after the sixth byte it presents a registered decision: accept or reject, a code naming the rule that decided, and the slot index for an exact hit.

Software loads the slots, the two hash words and the mode word through a simple write port. A programmable unicast count splits the slot bank. Slots below the count match only unicast destinations, and the rest match only group (multicast) destinations. Each slot has a live flag. Writing a slot's low word takes the slot out of service, and writing its high word puts it back, so a slot is never compared while it is half updated.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset no decision is pending, every slot is out of service, both hash words are zero, both modes are off and the unicast count is 0, so any frame is rejected with rule code 0.
- R2: A byte presented with `da_valid` and `da_sof` is destination byte 0, and the next five valid bytes (idle cycles allowed between them) are bytes 1..5. Valid bytes arriving before any start marker are ignored. A new start marker restarts collection. Exactly one decision pulse appears on `dec_valid` in the cycle after byte 5 is presented.
- R3: The address vector is bytes 5..0 with byte 0 in bits 7:0. A slot matches when it is live and its high word bits 15:0 equal bytes 5..4 and its low word bits 31:0 equal bytes 3..0. An exact hit gives rule code 1 with the lowest matching slot index on `dec_slot`.
- R4: Writing a slot's low word takes that slot out of service, and writing its high word puts it back in service.
- R5: A frame is a group frame when bit 0 of byte 0 is 1. Slots with index below the unicast count match only non-group frames, and the others match only group frames. A count written above NSLOT is saturated to NSLOT.
- R6: Hash bit i (i = 0..5) is the XOR of every address bit whose position modulo 6 equals i.
- R7: The hash value selects bit h of the 64-bit table {high word, low word}. A set bit accepts a group frame with rule code 2. Non-group frames never consult the table.
- R8: With all-multicast on, every group frame is accepted with rule code 2, whatever the hash words hold.
- R9: With promiscuous mode on, a frame that no other rule accepts is accepted with rule code 3.
- R10: The rule priority is exact, then hash, then promiscuous. Code 0 means reject. `dec_accept` is high exactly when the code is non-zero. `dec_slot` is 0 unless the code is 1, and all decision outputs are 0 when `dec_valid` is low.
- R11: The write map is: slot k low word at 2k, slot k high word at 2k+1, hash low word at 2·NSLOT, hash high word at 2·NSLOT+1, and the mode word at 2·NSLOT+2. In the mode word, bit 0 is promiscuous, bit 1 is all-multicast, and the unicast count sits at bit 4 upward. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| da_valid | input | 1 | Destination byte valid |
| da_sof | input | 1 | Marks byte 0 of a destination address |
| da_byte | input | 8 | Destination address byte |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Frame accepted |
| dec_rule | output | 2 | Deciding rule: 0 none, 1 exact, 2 hash, 3 promiscuous |
| dec_slot | output | SLOT_W | Matching slot for an exact hit |

## Verification
The bench builds the block with NSLOT = 4. With four slots, a unicast count of 0, a partial split and a full bank can all be reached in a few writes. A count written as 7 exercises saturation, and the unmapped addresses 11 to 15 of the 4-bit write space can be probed for ignored writes. Hash table entries in both words are reached through hand-computed fold values (0, 1, 5 and 33). Random frames and random writes then run against a behavioural model that is compared on every clock.

// File: rtl/rx_addr_filter_pkg.sv
package rx_addr_filter_pkg;

    localparam int ADDR_BITS = 48;
    localparam int HASH_BITS = 6;
    localparam int DA_BYTES  = ADDR_BITS / 8;

    localparam int MODE_PROMISC_BIT  = 0;
    localparam int MODE_ALLMULTI_BIT = 1;
    localparam int MODE_UCNT_LSB     = 4;

    typedef logic [ADDR_BITS-1:0] mac_addr_t;
    typedef logic [HASH_BITS-1:0] hash_idx_t;

    typedef enum logic [1:0] {
        RULE_NONE    = 2'd0,
        RULE_EXACT   = 2'd1,
        RULE_HASH    = 2'd2,
        RULE_PROMISC = 2'd3
    } rule_e;

    typedef struct packed {
        logic allmulti;
        logic promisc;
    } mode_t;

    // Fold all address bits onto six hash bits by position modulo six.
    function automatic hash_idx_t fold_hash(input mac_addr_t a);
        hash_idx_t h;
        h = '0;
        for (int j = 0; j < ADDR_BITS; j++) begin
            h[j % HASH_BITS] = h[j % HASH_BITS] ^ a[j];
        end
        return h;
    endfunction

    function automatic logic is_group(input mac_addr_t a);
        return a[0];
    endfunction

endpackage

// File: rtl/rx_da_collect.sv
module rx_da_collect
    import rx_addr_filter_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      da_valid,
    input  logic      da_sof,
    input  logic [7:0] da_byte,
    output mac_addr_t addr,
    output logic      done
);
    localparam int POS_W = $clog2(DA_BYTES);

    logic [DA_BYTES-2:0][7:0] held_q;
    logic [POS_W-1:0]         pos_q;   // 0 = waiting for a start marker

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
            pos_q  <= '0;
        end else if (da_valid) begin
            if (da_sof) begin
                held_q[0] <= da_byte;
                pos_q     <= POS_W'(1);
            end else if (pos_q != '0) begin
                if (pos_q == POS_W'(DA_BYTES - 1)) begin
                    pos_q <= '0;
                end else begin
                    held_q[pos_q] <= da_byte;
                    pos_q         <= pos_q + POS_W'(1);
                end
            end
        end
    end

    // Last byte is used straight from the input so the decision lands one cycle later.
    assign done = da_valid && !da_sof && (pos_q == POS_W'(DA_BYTES - 1));
    assign addr = {da_byte, held_q};

endmodule

// File: rtl/rx_slot_bank.sv
module rx_slot_bank
    import rx_addr_filter_pkg::*;
#(
    parameter int NSLOT  = 8,
    parameter int CFG_AW = 5,
    parameter int UCW    = 4,
    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CFG_AW-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [UCW-1:0]    ucnt,
    input  mac_addr_t         look_addr,
    output logic              hit,
    output logic [SLOT_W-1:0] hit_idx,
    output logic [NSLOT-1:0]  live
);
    logic [NSLOT-1:0] match;
    logic             grp;

    assign grp = is_group(look_addr);

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        logic [31:0] lo_q;
        logic [15:0] hi_q;
        logic        live_q;
        logic        ucast_slot;

        always_ff @(posedge clk) begin
            if (rst) begin
                lo_q   <= '0;
                hi_q   <= '0;
                live_q <= 1'b0;
            end else if (wr_en && wr_addr == CFG_AW'(2 * k)) begin
                lo_q   <= wr_data;
                live_q <= 1'b0;
            end else if (wr_en && wr_addr == CFG_AW'(2 * k + 1)) begin
                hi_q   <= wr_data[15:0];
                live_q <= 1'b1;
            end
        end

        assign ucast_slot = UCW'(k) < ucnt;
        assign match[k]   = live_q && (look_addr == {hi_q, lo_q}) && (ucast_slot != grp);
        assign live[k]    = live_q;
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int k = NSLOT - 1; k >= 0; k--) begin
            if (match[k]) begin
                hit     = 1'b1;
                hit_idx = SLOT_W'(k);
            end
        end
    end

endmodule

// File: rtl/rx_hash_table.sv
module rx_hash_table
    import rx_addr_filter_pkg::*;
#(
    parameter int CFG_AW  = 5,
    parameter int LO_ADDR = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CFG_AW-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              allmulti,
    input  mac_addr_t         look_addr,
    output logic              hit
);
    logic [63:0] table_q;
    hash_idx_t   idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            table_q <= '0;
        end else if (wr_en && wr_addr == CFG_AW'(LO_ADDR)) begin
            table_q[31:0] <= wr_data;
        end else if (wr_en && wr_addr == CFG_AW'(LO_ADDR + 1)) begin
            table_q[63:32] <= wr_data;
        end
    end

    assign idx = fold_hash(look_addr);
    assign hit = is_group(look_addr) && (allmulti || table_q[idx]);

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rx_addr_filter_pkg::*;
#(
    parameter int NSLOT = 8,
    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int CFG_AW = $clog2(2 * NSLOT + 3)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              da_valid,
    input  logic              da_sof,
    input  logic [7:0]        da_byte,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic [1:0]        dec_rule,
    output logic [SLOT_W-1:0] dec_slot
);
    localparam int UCW       = $clog2(NSLOT + 1);
    localparam int HASH_ADDR = 2 * NSLOT;
    localparam int MODE_ADDR = 2 * NSLOT + 2;

    mac_addr_t         addr;
    logic              done;
    logic              exact_hit;
    logic [SLOT_W-1:0] exact_idx;
    logic              hash_hit;
    logic [NSLOT-1:0]  slot_live;
    mode_t             mode_q;
    logic              promisc_q;
    logic [UCW-1:0]    ucnt_q;
    logic [UCW-1:0]    ucnt_wr;
    rule_e             rule_n;
    logic [SLOT_W-1:0] slot_n;

    rx_da_collect u_collect (
        .clk      (clk),
        .rst      (rst),
        .da_valid (da_valid),
        .da_sof   (da_sof),
        .da_byte  (da_byte),
        .addr     (addr),
        .done     (done)
    );

    rx_slot_bank #(.NSLOT(NSLOT), .CFG_AW(CFG_AW), .UCW(UCW)) u_slots (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_we),
        .wr_addr   (cfg_addr),
        .wr_data   (cfg_wdata),
        .ucnt      (ucnt_q),
        .look_addr (addr),
        .hit       (exact_hit),
        .hit_idx   (exact_idx),
        .live      (slot_live)
    );

    rx_hash_table #(.CFG_AW(CFG_AW), .LO_ADDR(HASH_ADDR)) u_hash (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_we),
        .wr_addr   (cfg_addr),
        .wr_data   (cfg_wdata),
        .allmulti  (mode_q.allmulti),
        .look_addr (addr),
        .hit       (hash_hit)
    );

    // Mode word: switches plus a saturating unicast slot count.
    assign ucnt_wr = cfg_wdata[MODE_UCNT_LSB +: UCW];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            ucnt_q <= '0;
        end else if (cfg_we && cfg_addr == CFG_AW'(MODE_ADDR)) begin
            mode_q.promisc  <= cfg_wdata[MODE_PROMISC_BIT];
            mode_q.allmulti <= cfg_wdata[MODE_ALLMULTI_BIT];
            ucnt_q          <= (ucnt_wr > UCW'(NSLOT)) ? UCW'(NSLOT) : ucnt_wr;
        end
    end

    assign promisc_q = mode_q.promisc;

    always_comb begin
        rule_n = RULE_NONE;
        slot_n = '0;
        if (exact_hit) begin
            rule_n = RULE_EXACT;
            slot_n = exact_idx;
        end else if (hash_hit) begin
            rule_n = RULE_HASH;
        end else if (mode_q.promisc) begin
            rule_n = RULE_PROMISC;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !done) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            dec_rule   <= RULE_NONE;
            dec_slot   <= '0;
        end else begin
            dec_valid  <= 1'b1;
            dec_accept <= (rule_n != RULE_NONE);
            dec_rule   <= rule_n;
            dec_slot   <= slot_n;
        end
    end

endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk
    import rx_addr_filter_pkg::*;
#(
    parameter int NSLOT  = 8,
    parameter int CFG_AW = 5,
    parameter int SLOT_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic              da_valid,
    input logic              da_sof,
    input logic              dec_valid,
    input logic              dec_accept,
    input logic [1:0]        dec_rule,
    input logic [SLOT_W-1:0] dec_slot,
    input logic              promisc_q,
    input logic [NSLOT-1:0]  slot_live
);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!dec_valid && slot_live == '0));

    p_after_last_byte_r2: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> $past(da_valid && !da_sof));

    p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        dec_valid |=> !dec_valid);

    p_low_disables_r4: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_we && cfg_addr == CFG_AW'(0)) |-> !slot_live[0]);

    p_high_enables_r4: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_we && cfg_addr == CFG_AW'(1)) |-> slot_live[0]);

    p_promisc_source_r9: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_rule == RULE_PROMISC) |-> $past(promisc_q));

    p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> (dec_rule == RULE_NONE && !dec_accept && dec_slot == '0));

    p_slot_only_exact_r10: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_rule != RULE_EXACT) |-> dec_slot == '0);

endmodule

bind rx_addr_filter rx_addr_filter_chk #(
    .NSLOT  (NSLOT),
    .CFG_AW (CFG_AW),
    .SLOT_W (SLOT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .da_valid   (da_valid),
    .da_sof     (da_sof),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept),
    .dec_rule   (dec_rule),
    .dec_slot   (dec_slot),
    .promisc_q  (promisc_q),
    .slot_live  (slot_live)
);

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;

    localparam int N      = 4;
    localparam int SW     = 2;
    localparam int AW     = 4;
    localparam int HLO    = 2 * N;
    localparam int HHI    = 2 * N + 1;
    localparam int MODE   = 2 * N + 2;
    localparam time TCLK  = 20ns;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          da_valid = 1'b0;
    logic          da_sof = 1'b0;
    logic [7:0]    da_byte = '0;
    logic          dec_valid;
    logic          dec_accept;
    logic [1:0]    dec_rule;
    logic [SW-1:0] dec_slot;

    int total = 0;
    int bad = 0;

    always #(TCLK / 2) clk = ~clk;

    rx_addr_filter #(.NSLOT(N)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .da_valid   (da_valid),
        .da_sof     (da_sof),
        .da_byte    (da_byte),
        .dec_valid  (dec_valid),
        .dec_accept (dec_accept),
        .dec_rule   (dec_rule),
        .dec_slot   (dec_slot)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_lo [N];
    logic [15:0] m_hi [N];
    bit          m_live [N];
    logic [31:0] m_hlo, m_hhi;
    bit          m_prom, m_amc;
    int          m_ucnt;
    logic [7:0]  m_b [6];
    int          m_pos;
    bit          e_valid;
    int          e_rule, e_slot;

    function automatic int ref_hash(logic [47:0] a);
        int h = 0;
        int i = 0;
        for (int oct = 0; oct < 6; oct++) begin
            for (int bt = 0; bt < 8; bt++) begin
                if (a[oct * 8 + bt]) h = h ^ (1 << i);
                i = (i == 5) ? 0 : i + 1;
            end
        end
        return h;
    endfunction

    task automatic ref_decide(logic [47:0] a);
        bit grp = a[0];
        int h;
        bit hb;
        e_rule = 0;
        e_slot = 0;
        for (int k = 0; k < N; k++) begin
            if (e_rule == 0 && m_live[k] && a == {m_hi[k], m_lo[k]} &&
                ((k < m_ucnt) ? !grp : grp)) begin
                e_rule = 1;
                e_slot = k;
            end
        end
        if (e_rule == 0 && grp) begin
            h = ref_hash(a);
            hb = (h < 32) ? m_hlo[h] : m_hhi[h - 32];
            if (m_amc || hb) e_rule = 2;
        end
        if (e_rule == 0 && m_prom) e_rule = 3;
    endtask

    always @(posedge clk) begin
        e_valid = 0;
        e_rule  = 0;
        e_slot  = 0;
        if (rst) begin
            for (int k = 0; k < N; k++) begin
                m_lo[k] = '0; m_hi[k] = '0; m_live[k] = 0;
            end
            m_hlo = '0; m_hhi = '0; m_prom = 0; m_amc = 0; m_ucnt = 0; m_pos = 0;
        end else begin
            if (da_valid) begin
                if (da_sof) begin
                    m_b[0] = da_byte;
                    m_pos = 1;
                end else if (m_pos > 0) begin
                    m_b[m_pos] = da_byte;
                    if (m_pos == 5) begin
                        e_valid = 1;
                        ref_decide({m_b[5], m_b[4], m_b[3], m_b[2], m_b[1], m_b[0]});
                        m_pos = 0;
                    end else begin
                        m_pos++;
                    end
                end
            end
            if (cfg_we) begin
                if (int'(cfg_addr) < 2 * N) begin
                    if (cfg_addr[0] == 1'b0) begin
                        m_lo[cfg_addr / 2] = cfg_wdata; m_live[cfg_addr / 2] = 0;
                    end else begin
                        m_hi[cfg_addr / 2] = cfg_wdata[15:0]; m_live[cfg_addr / 2] = 1;
                    end
                end else if (int'(cfg_addr) == HLO) m_hlo = cfg_wdata;
                else if (int'(cfg_addr) == HHI) m_hhi = cfg_wdata;
                else if (int'(cfg_addr) == MODE) begin
                    m_prom = cfg_wdata[0];
                    m_amc  = cfg_wdata[1];
                    m_ucnt = (int'(cfg_wdata[6:4]) > N) ? N : int'(cfg_wdata[6:4]);
                end
            end
        end
    end

    function automatic string tag_of(int r);
        case (r)
            1: return "R3";
            2: return "R7";
            3: return "R9";
            default: return "R10";
        endcase
    endfunction

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        total++;
        if (dec_valid !== e_valid || dec_rule !== 2'(e_rule) || dec_slot !== SW'(e_slot) ||
            dec_accept !== (e_valid && e_rule != 0)) begin
            bad++;
            $display("FAIL %s model: actual v=%0b acc=%0b rule=%0d slot=%0d expected v=%0b rule=%0d slot=%0d",
                     tag_of(e_rule), dec_valid, dec_accept, dec_rule, dec_slot, e_valid, e_rule, e_slot);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_slot(int k, logic [47:0] a);
        wr(2 * k, a[31:0]);
        wr(2 * k + 1, {16'h0, a[47:32]});
    endtask

    function automatic logic [31:0] mode_word(bit p, bit am, int uc);
        return (32'(uc) << 4) | (32'(am) << 1) | 32'(p);
    endfunction

    task automatic send(logic [47:0] a, bit gaps);
        for (int b = 0; b < 6; b++) begin
            @(negedge clk);
            da_valid = 1'b1; da_sof = (b == 0); da_byte = a[8 * b +: 8];
            if (gaps && b < 5) begin
                @(negedge clk);
                da_valid = 1'b0; da_sof = 1'b0;
            end
        end
        @(negedge clk);
        da_valid = 1'b0; da_sof = 1'b0;
    endtask

    // send a frame and check the decision in the cycle after byte 5
    task automatic frame(string tag, logic [47:0] a, int rule, int slot);
        send(a, 1'b0);
        check({tag, " valid"}, int'(dec_valid), 1);
        check({tag, " rule"}, int'(dec_rule), rule);
        check({tag, " slot"}, int'(dec_slot), slot);
        check({tag, " accept"}, int'(dec_accept), int'(rule != 0));
    endtask

    localparam logic [47:0] STA  = 48'h5544_3322_1100;
    localparam logic [47:0] STB  = 48'h0a0b_0c0d_0e02;
    localparam logic [47:0] MC1  = 48'h0302_015e_0001;
    localparam logic [47:0] UC2  = 48'hccbb_aa99_8876;
    localparam logic [47:0] H0   = 48'hffff_ffff_ffff;
    localparam logic [47:0] H1   = 48'h0000_0000_0001;
    localparam logic [47:0] H5   = 48'h0000_0000_0101;
    localparam logic [47:0] H33  = 48'h0000_0000_0021;
    localparam logic [47:0] U4   = 48'h0000_0000_0100;

    initial begin
        #(TCLK * 150000);
        bad++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 no decision after reset", int'(dec_valid), 0);
        frame("R1 empty filter rejects", STA, 0, 0);
        frame("R1 empty filter rejects group", H0, 0, 0);

        // R3 / R11: station address in slot 0, one unicast slot
        wr(MODE, mode_word(0, 0, 1));
        set_slot(0, STA);
        frame("R3 station exact", STA, 1, 0);
        frame("R3 one byte off", STA ^ 48'h0000_0100_0000, 0, 0);

        // R4: low word write takes slot out of service
        wr(0, STB[31:0]);
        frame("R4 old entry after low write", STA, 0, 0);
        frame("R4 new entry half written", STB, 0, 0);
        wr(1, {16'h0, STB[47:32]});
        frame("R4 high write re-enables", STB, 1, 0);

        // R5: unicast/multicast split
        set_slot(1, MC1);
        frame("R5 group slot above count", MC1, 1, 1);
        wr(MODE, mode_word(0, 0, 2));
        frame("R5 group frame in unicast slot", MC1, 0, 0);
        set_slot(2, UC2);
        frame("R5 unicast frame in group slot", UC2, 0, 0);
        wr(MODE, mode_word(0, 0, 7));
        frame("R5 count saturates to NSLOT", UC2, 1, 2);
        wr(MODE, mode_word(0, 0, 0));
        frame("R5 count zero blocks unicast", STB, 0, 0);
        set_slot(3, MC1);
        frame("R3 lowest slot wins", MC1, 1, 1);
        wr(2, 32'h0);
        frame("R3 next slot after disable", MC1, 1, 3);

        // R6 / R7: hash table
        check("R6 fold of broadcast", ref_hash(H0), 0);
        check("R6 fold h1", ref_hash(H1), 1);
        check("R6 fold h5", ref_hash(H5), 5);
        check("R6 fold h33", ref_hash(H33), 33);
        frame("R7 empty table", H5, 0, 0);
        wr(HLO, 32'h0000_0030);
        frame("R7 low word bit 5", H5, 2, 0);
        frame("R7 bit 1 clear", H1, 0, 0);
        frame("R7 unicast ignores hash bit 4", U4, 0, 0);
        frame("R6 broadcast bit 0 clear", H0, 0, 0);
        wr(HHI, 32'h0000_0002);
        frame("R7 high word bit 1", H33, 2, 0);
        wr(HLO, 32'h0000_0001);
        frame("R6 broadcast bit 0 set", H0, 2, 0);
        frame("R7 low word rewritten", H5, 0, 0);

        // R11: unmapped writes change nothing
        for (int a = MODE + 1; a < (1 << AW); a++) wr(a, 32'hffff_ffff);
        frame("R11 unmapped write no promisc", STB, 0, 0);
        frame("R11 unmapped write no allmulti", H1, 0, 0);

        // R8: all-multicast
        wr(MODE, mode_word(0, 1, 0));
        frame("R8 allmulti group", H1, 2, 0);
        frame("R8 allmulti leaves unicast", UC2 ^ 48'h1_0000, 0, 0);

        // R9 / R10: promiscuous and priority
        wr(MODE, mode_word(1, 0, 4));
        frame("R9 promisc unknown unicast", 48'h1234_5678_9a00, 3, 0);
        frame("R10 exact beats promisc", STB, 1, 0);
        frame("R10 hash beats promisc", H0, 2, 0);
        frame("R9 promisc unknown group", H1, 3, 0);

        // R2: byte collection
        wr(MODE, mode_word(0, 0, 4));
        send(STB, 1'b1);
        check("R2 gapped bytes valid", int'(dec_valid), 1);
        check("R2 gapped bytes rule", int'(dec_rule), 1);
        for (int b = 0; b < 6; b++) begin
            @(negedge clk);
            da_valid = 1'b1; da_sof = 1'b0; da_byte = STB[8 * b +: 8];
        end
        @(negedge clk);
        da_valid = 1'b0;
        check("R2 bytes without start ignored", int'(dec_valid), 0);
        for (int b = 0; b < 3; b++) begin
            @(negedge clk);
            da_valid = 1'b1; da_sof = (b == 0); da_byte = 8'hee;
        end
        frame("R2 restart on new start", STB, 1, 0);
        @(negedge clk);
        check("R2 single pulse", int'(dec_valid), 0);

        // random frames and writes against the model
        for (int it = 0; it < 400; it++) begin
            logic [47:0] a;
            int r = int'($urandom_range(0, 9));
            if (r == 0) wr(int'($urandom_range(0, (1 << AW) - 1)), $urandom);
            else if (r == 1) wr(MODE, mode_word(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                                                 int'($urandom_range(0, 7))));
            a = {$urandom, $urandom} & 48'hffff_ffff_ffff;
            if (r < 5) a = (r[0]) ? STB : MC1;
            send(a, bit'($urandom_range(0, 1)));
        end

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule